// File: doc/BRIEF.md
# Clock Source Selection Controller

This block holds the control side of a clock generator's source selection. Software writes a requested output clock source and a requested reference (internal or external). The block reports the choices that are actually in force through separate status outputs. A status output moves to a new value only when the requested source is reported available. The availability flags arrive from other clock domains, so each one passes through a synchronizer before the block acts on it.

The block also raises a one-cycle relock request toward the frequency-locked loop. It does this when the reference in force changes while the loop drives the output. A second function is the loop's frequency-range field. Writes to that field are dropped while the low-power flag is set. An accepted value reaches the applied-range output at once while the loop drives the output. Otherwise the value waits until the output returns to the loop.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal, sampled or updated on the rising clock edge.

Top module: `clksel_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `src_stat` is 2'b00, `ref_ext_stat` is 0, `relock_start` is 0 and `range_applied` is 0.
- R2: Source codes are 2'b00 for the loop output (ready flag `src_avail[0]`), 2'b01 for the internal reference (`src_avail[1]`) and 2'b10 for the external reference (`src_avail[2]`). When `src_req` differs from `src_stat` and the synchronized ready flag of the requested source is 1, `src_stat` takes the requested code at the next rising edge.
- R3: While the synchronized ready flag of the requested source is 0, `src_stat` keeps its value. After the raw flag rises and stays high, `src_stat` changes on the third rising edge, because of the two synchronizer flops.
- R4: A request of 2'b11 is reserved, and `src_stat` holds its value while it is applied.
- R5: `ref_ext_req` (0 internal, 1 external) is copied to `ref_ext_stat` at the next edge, provided the synchronized ready flag of that reference (`src_avail[1]` or `src_avail[2]`) is 1. Otherwise `ref_ext_stat` holds.
- R6: `relock_start` is high for exactly one cycle, on the same edge at which `ref_ext_stat` changes, and only if `src_stat` is 2'b00 at that moment. In every other cycle it is 0.
- R7: A range write (`range_wr` = 1) made while `low_power` = 1 is discarded. Neither the pending value nor `range_applied` changes.
- R8: An accepted range write made while `src_stat` is 2'b00 appears on `range_applied` at the next edge.
- R9: An accepted range write made while `src_stat` is not 2'b00 leaves `range_applied` unchanged. The value appears there one edge after `src_stat` becomes 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 2 | Requested output clock source code |
| ref_ext_req | input | 1 | Requested reference: 0 internal, 1 external |
| src_avail | input | 3 | Raw ready flags: [0] loop, [1] internal, [2] external |
| low_power | input | 1 | Low-power flag, blocks range writes |
| range_wr | input | 1 | Range write strobe |
| range_wdata | input | RANGE_W | Range value to write |
| src_stat | output | 2 | Output clock source in force |
| ref_ext_stat | output | 1 | Reference in force |
| relock_start | output | 1 | One-cycle loop relock request |
| range_applied | output | RANGE_W | Range value applied to the loop |

## Verification
The select, reference and range inputs are registered once. Their effects on `src_stat`, `ref_ext_stat`, `relock_start` and `range_applied` are therefore due at the first rising edge after the inputs are driven. A ready flag needs three edges before a switch it enables is visible. A deferred range value lands one edge after the source status returns to the loop. The bench drives inputs on the falling edge and moves its reference model at the rising edge, so each result is compared in the half-cycle after the edge where it falls due. The directed cases wait exactly the synchronizer depth before expecting a pending switch.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int unsigned SRC_W = 2;
  localparam int unsigned NSRC  = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_FLL = 2'b00,
    SRC_INT = 2'b01,
    SRC_EXT = 2'b10,
    SRC_RSV = 2'b11
  } clk_src_e;

  // Ready flag index for each selectable source
  localparam int unsigned AV_FLL = 0;
  localparam int unsigned AV_INT = 1;
  localparam int unsigned AV_EXT = 2;

  // True when code names a real source whose synchronized flag is set
  function automatic logic src_ready(input clk_src_e code, input logic [NSRC-1:0] av);
    case (code)
      SRC_FLL: src_ready = av[AV_FLL];
      SRC_INT: src_ready = av[AV_INT];
      SRC_EXT: src_ready = av[AV_EXT];
      default: src_ready = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

  // R3: the last stage only ever takes the previous stage's old value
  a_r3_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES > 1) |=> (chain[STAGES-1] == $past(chain[STAGES-2])));
endmodule

// File: rtl/clksel_src_ctrl.sv
module clksel_src_ctrl
  import clksel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  clk_src_e        req,
  input  logic [NSRC-1:0] av_sync,
  output clk_src_e        stat
);
  clk_src_e stat_q;
  logic     want_change;
  logic     tgt_ok;

  assign want_change = (req != SRC_RSV) && (req != stat_q);
  assign tgt_ok      = src_ready(req, av_sync);

  always_ff @(posedge clk) begin
    if (!rst_n)                   stat_q <= SRC_FLL;
    else if (want_change && tgt_ok) stat_q <= req;
  end

  assign stat = stat_q;

  // R2: status never shows the reserved code
  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q != SRC_RSV);
  // R3: an unavailable target leaves the status alone
  a_r3_hold_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (req != SRC_RSV && !src_ready(req, av_sync)) |=> $stable(stat_q));
  // R4: the reserved request holds the status
  a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req == SRC_RSV) |=> $stable(stat_q));
  // R2: a ready, differing request is taken on the next edge
  a_r2_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (req != SRC_RSV && src_ready(req, av_sync)) |=> (stat_q == $past(req)));
endmodule

// File: rtl/clksel_ref_ctrl.sv
module clksel_ref_ctrl
  import clksel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_req,
  input  logic [NSRC-1:0] av_sync,
  input  clk_src_e        src_stat,
  output logic            ref_stat,
  output logic            relock
);
  logic ref_q;
  logic relock_q;
  logic tgt_ok;
  logic do_switch;

  assign tgt_ok    = ref_req ? av_sync[AV_EXT] : av_sync[AV_INT];
  assign do_switch = (ref_req != ref_q) && tgt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      relock_q <= 1'b0;
    end else begin
      if (do_switch) ref_q <= ref_req;
      relock_q <= do_switch && (src_stat == SRC_FLL);
    end
  end

  assign ref_stat = ref_q;
  assign relock   = relock_q;

  // R6: a relock request only accompanies a reference change
  a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    relock_q |-> (ref_q != $past(ref_q)));
  // R6: no relock request when the loop was not driving the output
  a_r6_only_fll: assert property (@(posedge clk) disable iff (!rst_n)
    relock_q |-> ($past(src_stat) == SRC_FLL));
  // R5: reference status holds while the target is not ready
  a_r5_hold_unready: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_ok |=> $stable(ref_q));
endmodule

// File: rtl/clksel_range.sv
module clksel_range
  import clksel_pkg::*;
#(
  parameter int unsigned RANGE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               low_power,
  input  logic               wr,
  input  logic [RANGE_W-1:0] wdata,
  input  clk_src_e           src_stat,
  output logic [RANGE_W-1:0] applied
);
  logic [RANGE_W-1:0] pend_q;
  logic [RANGE_W-1:0] app_q;
  logic               accept;
  logic               fll_on;

  assign accept = wr && !low_power;
  assign fll_on = (src_stat == SRC_FLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      app_q  <= '0;
    end else begin
      if (accept) pend_q <= wdata;
      if (fll_on) app_q <= accept ? wdata : pend_q;
    end
  end

  assign applied = app_q;

  // R7: writes under low power change nothing
  a_r7_lp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && low_power) |=> $stable(pend_q));
  // R9: applied range frozen while the loop is not the output
  a_r9_hold_off_fll: assert property (@(posedge clk) disable iff (!rst_n)
    !fll_on |=> $stable(app_q));
  // R8: accepted write in loop mode lands on the next edge
  a_r8_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fll_on) |=> (app_q == $past(wdata)));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned RANGE_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_req,
  input  logic               ref_ext_req,
  input  logic [2:0]         src_avail,
  input  logic               low_power,
  input  logic               range_wr,
  input  logic [RANGE_W-1:0] range_wdata,
  output logic [1:0]         src_stat,
  output logic               ref_ext_stat,
  output logic               relock_start,
  output logic [RANGE_W-1:0] range_applied
);
  logic [NSRC-1:0] av_sync;
  clk_src_e        stat_e;

  clksel_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_avail),
    .q     (av_sync)
  );

  clksel_src_ctrl u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (clk_src_e'(src_req)),
    .av_sync (av_sync),
    .stat    (stat_e)
  );

  clksel_ref_ctrl u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_req  (ref_ext_req),
    .av_sync  (av_sync),
    .src_stat (stat_e),
    .ref_stat (ref_ext_stat),
    .relock   (relock_start)
  );

  clksel_range #(.RANGE_W(RANGE_W)) u_range (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_power (low_power),
    .wr        (range_wr),
    .wdata     (range_wdata),
    .src_stat  (stat_e),
    .applied   (range_applied)
  );

  assign src_stat = stat_e;

  // R1: first cycle after reset shows the reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (src_stat == 2'b00 && !ref_ext_stat && !relock_start && range_applied == '0));
endmodule

// File: tb/sim_clksel_ctrl.sv
module sim_clksel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    src_req;
  logic          ref_ext_req;
  logic [2:0]    src_avail;
  logic          low_power;
  logic          range_wr;
  logic [RW-1:0] range_wdata;
  logic [1:0]    src_stat;
  logic          ref_ext_stat;
  logic          relock_start;
  logic [RW-1:0] range_applied;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [2:0]    m_s1, m_s2;
  logic [1:0]    m_src;
  logic          m_ref, m_rl;
  logic [RW-1:0] m_pend, m_app;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksel_ctrl #(.RANGE_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .ref_ext_req(ref_ext_req),
    .src_avail(src_avail), .low_power(low_power), .range_wr(range_wr),
    .range_wdata(range_wdata), .src_stat(src_stat), .ref_ext_stat(ref_ext_stat),
    .relock_start(relock_start), .range_applied(range_applied)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic ready_of(input logic [1:0] code, input logic [2:0] av);
    case (code)
      2'b00: return av[0];
      2'b01: return av[1];
      2'b10: return av[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_src = 2'b00; m_ref = 1'b0; m_rl = 1'b0;
    m_pend = '0; m_app = '0;
  endtask

  // one rising edge of the model, from the requirements
  task automatic model_edge();
    logic [1:0]    n_src;
    logic          n_ref, n_rl, refsw;
    logic [RW-1:0] n_pend, n_app;
    n_src = m_src;
    if (src_req != 2'b11 && src_req != m_src && ready_of(src_req, m_s2)) n_src = src_req;
    refsw = (ref_ext_req != m_ref) && (ref_ext_req ? m_s2[2] : m_s2[1]);
    n_ref = refsw ? ref_ext_req : m_ref;
    n_rl  = refsw && (m_src == 2'b00);
    n_pend = (range_wr && !low_power) ? range_wdata : m_pend;
    n_app  = (m_src == 2'b00) ? n_pend : m_app;
    m_s2 = m_s1; m_s1 = src_avail;
    m_src = n_src; m_ref = n_ref; m_rl = n_rl; m_pend = n_pend; m_app = n_app;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic cmp_model();
    chk("R2 src_stat", src_stat, m_src);
    chk("R5 ref_ext_stat", ref_ext_stat, m_ref);
    chk("R6 relock_start", relock_start, m_rl);
    chk("R9 range_applied", range_applied, m_app);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    src_req = 2'b00; ref_ext_req = 1'b0; src_avail = 3'b000; low_power = 1'b0;
    range_wr = 1'b0; range_wdata = '0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 src_stat", src_stat, 0);
    chk("R1 ref_ext_stat", ref_ext_stat, 0);
    chk("R1 relock_start", relock_start, 0);
    chk("R1 range_applied", range_applied, 0);

    src_avail = 3'b111;
    repeat (3) step();
    // R2 switch to external
    src_req = 2'b10; step();
    chk("R2 switch to ext", src_stat, 2);
    // R4 reserved code holds
    src_req = 2'b11; step(); step();
    chk("R4 reserved hold", src_stat, 2);
    // R3 unavailable target holds, then switches on third edge
    src_avail = 3'b101; repeat (3) step();
    src_req = 2'b01; step(); step();
    chk("R3 hold unready", src_stat, 2);
    src_avail = 3'b111; step();
    chk("R3 edge1", src_stat, 2);
    step();
    chk("R3 edge2", src_stat, 2);
    step();
    chk("R3 edge3", src_stat, 1);
    // R9 write outside loop mode is deferred
    range_wr = 1'b1; range_wdata = 2'd3; step(); range_wr = 1'b0;
    chk("R9 deferred", range_applied, 0);
    src_req = 2'b00; step();
    chk("R9 back to fll", src_stat, 0);
    chk("R9 not yet", range_applied, 0);
    step();
    chk("R9 applied", range_applied, 3);
    // R8 immediate in loop mode
    range_wr = 1'b1; range_wdata = 2'd1; step(); range_wr = 1'b0;
    chk("R8 immediate", range_applied, 1);
    // R7 low power blocks write
    low_power = 1'b1; range_wr = 1'b1; range_wdata = 2'd2; step();
    range_wr = 1'b0; low_power = 1'b0;
    chk("R7 blocked", range_applied, 1);
    step();
    chk("R7 pending kept", range_applied, 1);
    // R5/R6 reference change in loop mode pulses relock
    ref_ext_req = 1'b1; step();
    chk("R5 ref ext", ref_ext_stat, 1);
    chk("R6 pulse", relock_start, 1);
    step();
    chk("R6 single cycle", relock_start, 0);
    // R6 no pulse outside loop mode
    src_req = 2'b10; step();
    ref_ext_req = 1'b0; step();
    chk("R5 ref int", ref_ext_stat, 0);
    chk("R6 no pulse off fll", relock_start, 0);
    // R5 reference hold when not ready
    src_avail = 3'b011; repeat (3) step();
    ref_ext_req = 1'b1; step(); step();
    chk("R5 hold unready", ref_ext_stat, 0);

    // random phase against the model
    void'($urandom(32'd1234));
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      src_avail   = {($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0};
      if ($urandom % 3 == 0) src_req = 2'($urandom);
      if ($urandom % 4 == 0) ref_ext_req = 1'($urandom);
      low_power   = ($urandom % 3) == 0;
      range_wr    = ($urandom % 2) == 0;
      range_wdata = RW'($urandom);
      step();
      cmp_model();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule